// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven serial management master for external PHY devices. Software programs four 32-bit registers and the block shifts complete 64-bit management frames onto a two-wire bus. One wire is the management clock, which the block generates. The other is a bidirectional data line, brought out as separate output, output-enable and input pins. Both frame formats are supported, the short-address format and the extended-address format, and one select bit in the configuration register chooses between them.

In the extended format, a write to the address register sends an address frame on its own. In either format, a write to the data register sends a write frame, and setting the go bit in the control register sends a read frame. For a read, the line is released during the turnaround, and a PHY that fails to pull the line low in the second turnaround bit causes a read error. A read error makes the data register return all ones.

A bus-busy flag covers every frame. A separate operation-busy flag covers only read and write frames. While a frame is in flight, writes to the control, address and data registers are dropped. The configuration register stays writable, so a frame stalled by a zero divider can be resumed.

Top module: `mgmt_serial_master`

The frame engine steps through these states:

| State | Meaning | Leaves for |
|---|---|---|
| IDLE | no frame | PRE, when a frame is launched |
| PRE | preamble, bits 0-31 | HDR |
| HDR | start code, opcode, port and device fields, bits 32-45 | TURN |
| TURN | turnaround, bits 46-47 | PAY |
| PAY | 16-bit payload, bits 48-63 | FIN |
| FIN | one clock of completion | IDLE |

Each move from PRE to PAY, and from PAY to FIN, happens on the management-clock falling edge that ends the last bit of the current state.

Register map, selected by `reg_addr`:
- Address 0 is CFG. Bit 0 is bus busy (read only). Bit 1 is read error (read only). Bit 2 selects the extended format when set. Bit 3 is a stored control bit. Bits [8+DIV_W-1:8] hold the divider.
- Address 1 is CTRL. Bits [4:0] are the device field, bits [9:5] are the port field, and bit 15 is the read go bit, which always reads 0.
- Address 2 is ADDR. Bits [15:0] hold the address.
- Address 3 is DATA. Bits [15:0] hold the data and bit 31 is operation busy.

## Requirements
- R1: After reset, all four registers read 0, `mdc_o` is 0, `mdio_oe` is 0 and `mdio_o` is 1.
- R2: With CFG bit 2 clear, a DATA write sends a frame made of 32 ones, start code 01, opcode 01, the 5-bit port field, the device field (the register number), turnaround 10 and the 16-bit data, most significant bit first. `mdio_oe` stays 1 for all 64 bits.
- R3: With CFG bit 2 set, an ADDR write sends 32 ones, 00, opcode 00, port, device, 10 and the address value. DATA bit 31 stays 0 while CFG bit 0 is 1.
- R4: With CFG bit 2 set, a DATA write sends 32 ones, 00, opcode 01, port, device, 10 and the data.
- R5: A CTRL write with bit 15 set sends a read frame whose header uses opcode 10 (start 01) in the short format and opcode 11 (start 00) in the extended format. `mdio_oe` is 0 for bits 46-63. The 16 bits sampled on the rising edges of bits 48-63 appear in DATA[15:0] after completion.
- R6: If the line is 1 at the rising edge of read bit 47, CFG bit 1 is set and DATA[15:0] reads 0xFFFF. A later valid read clears CFG bit 1.
- R7: CFG bit 0 is 1 throughout every frame, and DATA bit 31 is 1 throughout read and write frames. Both fall one system clock after the final falling edge of `mdc_o`.
- R8: The `mdc_o` period is 2×divider system clocks. `mdc_o` is 0 whenever no frame is in flight.
- R9: With a divider of 0, `mdc_o` holds still and a launched frame does not advance. A later CFG write with a nonzero divider lets the frame finish unchanged.
- R10: Writes to CTRL, ADDR or DATA while CFG bit 0 is 1 change no register and start no frame. An ADDR write with CFG bit 2 clear only stores the value.
- R11: `mdio_o` changes only on system clocks in which `mdc_o` falls.
- R12: CFG bits 2, 3 and the divider field read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 2 | register select |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational on reg_addr |
| mdc_o | output | 1 | management clock |
| mdio_o | output | 1 | data line output value |
| mdio_oe | output | 1 | data line output enable |
| mdio_i | input | 1 | data line input |

## Verification
Random frames mix all three frame kinds in both formats, with dividers of 1 to 3 and random port, device and payload fields. A PHY responder answers reads, and is sometimes absent so that the line floats high. Comparing the captured bit image against the expected frame tells start codes and opcodes apart per format and kind. It also catches field misplacement and errors in payload bit order. Directed cases separate a valid turnaround from a missing one, a dropped write from an accepted one, a stored-only short-format address write from a launched one, and a stalled zero-divider frame from a resumed one.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int FRAME_BITS = 64;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    // bit indices of the last bit in each frame section
    localparam logic [CNT_W-1:0] B_PRE_END = CNT_W'(31);
    localparam logic [CNT_W-1:0] B_HDR_END = CNT_W'(45);
    localparam logic [CNT_W-1:0] B_TA2     = CNT_W'(47);
    localparam logic [CNT_W-1:0] B_PAY     = CNT_W'(48);
    localparam logic [CNT_W-1:0] B_LAST    = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_HDR  = 3'd2,
        ST_TURN = 3'd3,
        ST_PAY  = 3'd4,
        ST_FIN  = 3'd5
    } frm_state_e;

    typedef enum logic [1:0] {
        RA_CFG  = 2'd0,
        RA_CTRL = 2'd1,
        RA_ADDR = 2'd2,
        RA_DATA = 2'd3
    } reg_sel_e;

    // Full 64-bit wire image, sent MSB first.
    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic        c45,
        input op_kind_e    kind,
        input logic [4:0]  port,
        input logic [4:0]  dev,
        input logic [15:0] pay
    );
        logic [1:0]  st;
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] body;
        st = c45 ? 2'b00 : 2'b01;
        case (kind)
            OP_ADDR:  op = 2'b00;
            OP_WRITE: op = 2'b01;
            default:  op = c45 ? 2'b11 : 2'b10;
        endcase
        ta   = (kind == OP_READ) ? 2'b11 : 2'b10;
        body = (kind == OP_READ) ? 16'hFFFF : pay;
        return {32'hFFFF_FFFF, st, op, port, dev, ta, body};
    endfunction

endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic             tick;

    // one half period is div system clocks; div of zero freezes the clock
    assign tick   = run && (div != '0) && (cnt_q >= div - ONE);
    assign rise_p = tick && !mdc;
    assign fall_p = tick && mdc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else if (div != '0) begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/mdm_frame_engine.sv
module mdm_frame_engine
    import mdm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        c45,
    input  op_kind_e    kind,
    input  logic [4:0]  port,
    input  logic [4:0]  dev,
    input  logic [15:0] pay,
    input  logic        rise_p,
    input  logic        fall_p,
    input  logic        mdio_i,
    output logic        run,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err
);

    frm_state_e              state_q;
    frm_state_e              state_d;
    logic [CNT_W-1:0]        cnt_q;
    logic [FRAME_BITS-1:0]   sr_q;
    logic                    is_rd_q;
    logic                    ta_bad_q;
    logic [15:0]             rd_sr_q;
    logic                    active;
    logic                    released;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                         state_d = ST_PRE;
            ST_PRE:  if (fall_p && cnt_q == B_PRE_END)  state_d = ST_HDR;
            ST_HDR:  if (fall_p && cnt_q == B_HDR_END)  state_d = ST_TURN;
            ST_TURN: if (fall_p && cnt_q == B_TA2)      state_d = ST_PAY;
            ST_PAY:  if (fall_p && cnt_q == B_LAST)     state_d = ST_FIN;
            ST_FIN:                                     state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // shift, bit count and receive datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sr_q     <= '1;
            is_rd_q  <= 1'b0;
            ta_bad_q <= 1'b0;
            rd_sr_q  <= '0;
        end else if (state_q == ST_IDLE && start) begin
            sr_q     <= make_frame(c45, kind, port, dev, pay);
            cnt_q    <= '0;
            is_rd_q  <= (kind == OP_READ);
            ta_bad_q <= 1'b0;
            rd_sr_q  <= '0;
        end else begin
            if (fall_p && cnt_q != B_LAST) begin
                sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b1};
                cnt_q <= cnt_q + CNT_ONE;
            end
            if (rise_p && is_rd_q) begin
                if (cnt_q == B_TA2) ta_bad_q <= mdio_i;
                if (cnt_q >= B_PAY) rd_sr_q  <= {rd_sr_q[14:0], mdio_i};
            end
        end
    end

    // outputs
    always_comb begin
        active   = (state_q == ST_PRE) || (state_q == ST_HDR) ||
                   (state_q == ST_TURN) || (state_q == ST_PAY);
        released = is_rd_q && ((state_q == ST_TURN) || (state_q == ST_PAY));
        run      = active;
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FIN);
        mdio_o   = active ? sr_q[FRAME_BITS-1] : 1'b1;
        mdio_oe  = active && !released;
        rd_data  = rd_sr_q;
        rd_err   = ta_bad_q;
    end

endmodule

// File: rtl/mdm_regs.sv
module mdm_regs
    import mdm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             bus_busy,
    input  logic             done,
    input  logic [15:0]      rd_data,
    input  logic             rd_err,
    output logic [31:0]      rdata,
    output logic             start,
    output logic             c45,
    output op_kind_e         kind,
    output logic [4:0]       port,
    output logic [4:0]       dev,
    output logic [15:0]      pay,
    output logic [DIV_W-1:0] div,
    output logic             op_busy
);

    localparam int DIV_LSB = 8;
    localparam int GO_BIT  = 15;

    reg_sel_e         sel;
    logic             acc_cfg;
    logic             acc_oth;
    logic             c45_q;
    logic             aux_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       port_q;
    logic [4:0]       dev_q;
    logic [15:0]      addr_q;
    logic [15:0]      data_q;
    logic             err_q;
    logic             op_busy_q;
    logic             rd_pend_q;
    logic             unused_wbits;

    assign unused_wbits = ^wdata[31:16];

    // write decode and frame launch
    always_comb begin
        sel     = reg_sel_e'(addr);
        acc_cfg = we && (sel == RA_CFG);
        acc_oth = we && !bus_busy;
        start   = acc_oth && (((sel == RA_CTRL) && wdata[GO_BIT]) ||
                              ((sel == RA_ADDR) && c45_q) ||
                               (sel == RA_DATA));
        kind    = (sel == RA_CTRL) ? OP_READ :
                  (sel == RA_ADDR) ? OP_ADDR : OP_WRITE;
        port    = (sel == RA_CTRL) ? wdata[9:5] : port_q;
        dev     = (sel == RA_CTRL) ? wdata[4:0] : dev_q;
        pay     = wdata[15:0];
        c45     = c45_q;
        div     = div_q;
        op_busy = op_busy_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45_q     <= 1'b0;
            aux_q     <= 1'b0;
            div_q     <= '0;
            port_q    <= '0;
            dev_q     <= '0;
            addr_q    <= '0;
            data_q    <= '0;
            err_q     <= 1'b0;
            op_busy_q <= 1'b0;
            rd_pend_q <= 1'b0;
        end else begin
            if (acc_cfg) begin
                c45_q <= wdata[2];
                aux_q <= wdata[3];
                div_q <= wdata[DIV_LSB +: DIV_W];
            end
            if (acc_oth) begin
                unique case (sel)
                    RA_CTRL: begin
                        port_q <= wdata[9:5];
                        dev_q  <= wdata[4:0];
                    end
                    RA_ADDR: addr_q <= wdata[15:0];
                    RA_DATA: data_q <= wdata[15:0];
                    RA_CFG:  ;
                endcase
            end
            if (start && kind != OP_ADDR) begin
                op_busy_q <= 1'b1;
                rd_pend_q <= (kind == OP_READ);
            end else if (done) begin
                op_busy_q <= 1'b0;
                rd_pend_q <= 1'b0;
                if (rd_pend_q) begin
                    err_q  <= rd_err;
                    data_q <= rd_err ? 16'hFFFF : rd_data;
                end
            end
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        unique case (sel)
            RA_CFG: begin
                rdata[0]                = bus_busy;
                rdata[1]                = err_q;
                rdata[2]                = c45_q;
                rdata[3]                = aux_q;
                rdata[DIV_LSB +: DIV_W] = div_q;
            end
            RA_CTRL: begin
                rdata[4:0] = dev_q;
                rdata[9:5] = port_q;
            end
            RA_ADDR: rdata[15:0] = addr_q;
            RA_DATA: begin
                rdata[15:0] = data_q;
                rdata[31]   = op_busy_q;
            end
        endcase
    end

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mdm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic             start;
    logic             c45;
    op_kind_e         kind;
    logic [4:0]       port;
    logic [4:0]       dev;
    logic [15:0]      pay;
    logic [DIV_W-1:0] div_w;
    logic             op_busy;
    logic             bus_busy;
    logic             done;
    logic [15:0]      rd_data;
    logic             rd_err;
    logic             run;
    logic             rise_p;
    logic             fall_p;

    mdm_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .bus_busy (bus_busy),
        .done     (done),
        .rd_data  (rd_data),
        .rd_err   (rd_err),
        .rdata    (reg_rdata),
        .start    (start),
        .c45      (c45),
        .kind     (kind),
        .port     (port),
        .dev      (dev),
        .pay      (pay),
        .div      (div_w),
        .op_busy  (op_busy)
    );

    mdm_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div    (div_w),
        .mdc    (mdc_o),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdm_frame_engine u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .c45     (c45),
        .kind    (kind),
        .port    (port),
        .dev     (dev),
        .pay     (pay),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .run     (run),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .busy    (bus_busy),
        .done    (done),
        .rd_data (rd_data),
        .rd_err  (rd_err)
    );

endmodule

// File: rtl/mdm_checker.sv
module mdm_checker #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mdc_o,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             bus_busy,
    input logic             op_busy,
    input logic [DIV_W-1:0] div
);

    // R7: busy drops one clock after the last MDC falling edge
    a_r7_busy_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy) |-> $past(mdc_o, 2) && !$past(mdc_o));

    // R7: operation busy lies inside bus busy
    a_r7_op_within_bus: assert property (@(posedge clk) disable iff (!rst_n)
        op_busy |-> bus_busy);

    // R8: clock parked low between frames
    a_r8_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_busy |-> !mdc_o);

    // R9: zero divider freezes the clock
    a_r9_div_zero_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> $stable(mdc_o));

    // R11: data changes only with a falling MDC
    a_r11_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc_o));

    // R5: line only driven during a frame
    a_r5_drive_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> bus_busy);

endmodule

bind mgmt_serial_master mdm_checker #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_o    (mdc_o),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .bus_busy (bus_busy),
    .op_busy  (op_busy),
    .div      (div_w)
);

// File: tb/mgmt_serial_master_tb_top.sv
module mgmt_serial_master_tb_top;

    localparam int CLK_P = 10;
    localparam int K_ADDR = 0;
    localparam int K_WR = 1;
    localparam int K_RD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc_o, mdio_o, mdio_oe, mdio_i;

    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b0;
    logic        phy_on = 1'b0;
    logic        rd_expect = 1'b0;
    logic [15:0] phy_val = '0;
    logic [63:0] cap = '0;
    logic [63:0] oecap = '0;
    int          rcnt = 0;
    time         t_r0 = 0;
    time         t_r1 = 0;
    int          nchk = 0;
    int          nfail = 0;
    bit          ended = 0;
    logic [15:0] data_sh = '0;
    logic [9:0]  ctrl_sh = '0;

    always #(CLK_P/2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    mgmt_serial_master dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // bus monitor and PHY responder
    always @(posedge mdc_o) begin
        if (rcnt < 64) begin
            cap[63-rcnt]   = mdio_i;
            oecap[63-rcnt] = mdio_oe;
        end
        if (rcnt == 0) t_r0 = $time;
        if (rcnt == 1) t_r1 = $time;
        rcnt = rcnt + 1;
    end

    always @(negedge mdc_o) begin
        if (rd_expect && phy_on && rcnt >= 47 && rcnt <= 63) begin
            phy_drv = 1'b1;
            phy_bit = (rcnt == 47) ? 1'b0 : phy_val[63-rcnt];
        end else begin
            phy_drv = 1'b0;
        end
    end

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run hung act=1 exp=0");
        summary();
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        do rd(2'd0, v); while (v[0]);
    endtask

    function automatic logic [31:0] cfg_word(input bit c45, input bit aux, input logic [7:0] dv);
        return {16'h0, dv, 4'b0, aux, c45, 2'b00};
    endfunction

    function automatic logic [63:0] exp_frame(input int k, input bit c45, input logic [4:0] p,
                                              input logic [4:0] d, input logic [15:0] v);
        logic [1:0] st;
        logic [1:0] op;
        st = c45 ? 2'b00 : 2'b01;
        if (k == K_ADDR)    op = 2'b00;
        else if (k == K_WR) op = 2'b01;
        else                op = c45 ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, st, op, p, d, 2'b10, v};
    endfunction

    task automatic run_txn(input int k, input bit c45, input logic [4:0] p, input logic [4:0] d,
                           input logic [15:0] v, input bit present, input logic [7:0] dv);
        logic [31:0] r;
        logic [63:0] e;
        string       tg;
        if (k == K_ADDR) c45 = 1'b1;
        wr(2'd0, cfg_word(c45, 1'b1, dv));
        if (k != K_RD) begin
            wr(2'd1, {22'h0, p, d});
            ctrl_sh = {p, d};
        end
        rd_expect = (k == K_RD);
        phy_on = present;
        phy_val = $urandom;
        rcnt = 0;
        if (k == K_ADDR)     wr(2'd2, {16'h0, v});
        else if (k == K_WR)  wr(2'd3, {16'h0, v});
        else begin
            wr(2'd1, {16'h0, 1'b1, 5'h0, p, d});
            ctrl_sh = {p, d};
        end
        rd(2'd0, r);
        chk(r[0] == 1'b1, "R7 bus busy mid-frame", {63'h0, r[0]}, 64'h1);
        rd(2'd3, r);
        chk(r[31] == (k != K_ADDR), "R7/R3 op busy mid-frame", {63'h0, r[31]}, {63'h0, k != K_ADDR});
        wait_idle();
        chk(rcnt == 64, "R8 rising edge count", 64'(rcnt), 64'd64);
        chk((t_r1 - t_r0) == time'(2 * dv * CLK_P), "R8 mdc period", 64'(t_r1 - t_r0), 64'(2 * dv * CLK_P));
        e = exp_frame(k, c45, p, d, v);
        tg = (k == K_ADDR) ? "R3 address frame" : (k == K_WR) ? (c45 ? "R4 write frame" : "R2 write frame")
                           : "R5 read header";
        if (k == K_RD) begin
            chk(cap[63:18] == e[63:18], tg, {18'h0, cap[63:18]}, {18'h0, e[63:18]});
            chk(oecap == {46'h3FFF_FFFF_FFFF, 18'h0}, "R5 line released", oecap, {46'h3FFF_FFFF_FFFF, 18'h0});
            data_sh = present ? phy_val : 16'hFFFF;
            rd(2'd3, r);
            chk(r[15:0] == data_sh, present ? "R5 read data" : "R6 error data", {48'h0, r[15:0]}, {48'h0, data_sh});
            rd(2'd0, r);
            chk(r[1] == !present, "R6 read error flag", {63'h0, r[1]}, {63'h0, !present});
        end else begin
            chk(cap == e, tg, cap, e);
            chk(oecap == '1, "R2 driven all bits", oecap, '1);
            if (k == K_WR) data_sh = v;
        end
        rd(2'd3, r);
        chk(r[31] == 1'b0 && r[15:0] == data_sh, "R7 op busy clear", {32'h0, r}, {48'h0, data_sh});
        rd_expect = 1'b0;
    endtask

    initial begin
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), r);
            chk(r == 32'h0, "R1 register reset", {32'h0, r}, 64'h0);
        end
        chk(mdc_o == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 pin reset",
            {61'h0, mdc_o, mdio_oe, mdio_o}, 64'h1);

        // R12 readback
        wr(2'd0, cfg_word(1'b1, 1'b1, 8'h05));
        rd(2'd0, r);
        chk(r == 32'h0000_050C, "R12 cfg readback", {32'h0, r}, 64'h050C);
        wr(2'd0, cfg_word(1'b0, 1'b1, 8'hA0));
        rd(2'd0, r);
        chk(r == 32'h0000_A008, "R12 cfg readback 2", {32'h0, r}, 64'hA008);

        // directed frames
        run_txn(K_WR,   1'b0, 5'h11, 5'h03, 16'hC3A5, 1'b1, 8'd1);
        run_txn(K_ADDR, 1'b1, 5'h1F, 5'h1E, 16'h8001, 1'b1, 8'd2);
        run_txn(K_WR,   1'b1, 5'h00, 5'h01, 16'h0F0F, 1'b1, 8'd3);
        run_txn(K_RD,   1'b0, 5'h05, 5'h0A, 16'h0000, 1'b1, 8'd1);
        run_txn(K_RD,   1'b1, 5'h0C, 5'h07, 16'h0000, 1'b1, 8'd2);
        run_txn(K_RD,   1'b0, 5'h13, 5'h02, 16'h0000, 1'b0, 8'd1);
        run_txn(K_RD,   1'b1, 5'h13, 5'h02, 16'h0000, 1'b1, 8'd1);

        // R10 short-format address write only stores
        wr(2'd0, cfg_word(1'b0, 1'b1, 8'd1));
        wr(2'd2, 32'h0000_BEEF);
        repeat (20) @(negedge clk);
        rd(2'd0, r);
        chk(r[0] == 1'b0 && mdc_o == 1'b0, "R10 no launch from address write", {62'h0, r[0], mdc_o}, 64'h0);
        rd(2'd2, r);
        chk(r[15:0] == 16'hBEEF, "R10 address stored", {48'h0, r[15:0]}, 64'hBEEF);

        // R10 writes dropped while busy
        wr(2'd0, cfg_word(1'b1, 1'b1, 8'd1));
        rcnt = 0;
        wr(2'd2, 32'h0000_1357);
        wr(2'd3, 32'h0000_1234);
        wr(2'd1, {16'h0, 1'b1, 15'h7FFF});
        wr(2'd2, 32'h0000_2468);
        wait_idle();
        repeat (50) @(negedge clk);
        chk(rcnt == 64, "R10 no extra frame", 64'(rcnt), 64'd64);
        rd(2'd3, r);
        chk(r[15:0] == data_sh, "R10 data unchanged", {48'h0, r[15:0]}, {48'h0, data_sh});
        rd(2'd1, r);
        chk(r[9:0] == ctrl_sh, "R10 control unchanged", {54'h0, r[9:0]}, {54'h0, ctrl_sh});
        rd(2'd2, r);
        chk(r[15:0] == 16'h1357, "R10 address unchanged", {48'h0, r[15:0]}, 64'h1357);
        chk(cap == exp_frame(K_ADDR, 1'b1, ctrl_sh[9:5], ctrl_sh[4:0], 16'h1357), "R3 address frame 2",
            cap, exp_frame(K_ADDR, 1'b1, ctrl_sh[9:5], ctrl_sh[4:0], 16'h1357));

        // R9 zero divider stalls, config write resumes
        wr(2'd0, cfg_word(1'b0, 1'b1, 8'd0));
        rcnt = 0;
        wr(2'd3, 32'h0000_00A5);
        repeat (100) @(negedge clk);
        rd(2'd0, r);
        chk(r[0] == 1'b1 && mdc_o == 1'b0 && rcnt == 0, "R9 stalled frame",
            {31'h0, r[0], mdc_o, 31'(rcnt)}, 64'h1_0000_0000);
        wr(2'd0, cfg_word(1'b0, 1'b1, 8'd2));
        wait_idle();
        chk(cap == exp_frame(K_WR, 1'b0, ctrl_sh[9:5], ctrl_sh[4:0], 16'h00A5), "R9 resumed frame",
            cap, exp_frame(K_WR, 1'b0, ctrl_sh[9:5], ctrl_sh[4:0], 16'h00A5));
        data_sh = 16'h00A5;

        // random mix
        for (int n = 0; n < 30; n++) begin
            int          k;
            logic [7:0]  dv;
            k = int'($urandom % 3);
            dv = 8'(1 + ($urandom % 3));
            run_txn(k, 1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
                    ($urandom % 4) != 0, dv);
        end

        summary();
    end

endmodule